// File: doc/BRIEF.md
# Double-Rate Burst-of-Two SRAM Front End

This block is a cycle-accurate, synthesizable model of a synchronous SRAM whose data buses run at double rate with a fixed burst of two words. On each rising edge of the main clock the block can take at most one command: an idle cycle, a read, or a write. Each command carries one address, and that address covers two data words. The two words travel in one clock period, one in the high phase and one in the low phase. Write data follows its command by one cycle. The first word is taken on the rising edge and the second on the falling edge. The block stores it without any handshake.

Reads return both words back to back. A mode input chooses between two latencies. In the delay-locked mode the first word arrives one and a half cycles after the command. In bypass mode it arrives after one cycle. Read words can be launched from a separate output clock pair or from the main clock, chosen by a parameter. A pair of complementary echo strobes follows the launch clock, so that a receiver can capture the words with the strobes alone. A second parameter sets the burst order. In narrow-word mode every burst starts at word 0 of its pair. In wide-word mode the address LSB picks the starting word. The storage is a small register array whose width and depth are parameters.

Top module: `ddr_burst2_sram`

## Requirements
- R1: While `rst` is high, and on the first edges after it is released, `rvalid` is 0 and `rdata` is all zeros.
- R2: Commands are sampled only on the rising edge of `clk`. With `ld_n`=0 and `rw_sel`=1 the command is a read. With `ld_n`=0 and `rw_sel`=0 it is a write. With `ld_n`=1 the cycle is idle.
- R3: A write command at rising edge T takes its first word from `wdata` at rising edge T+1 and its second word from `wdata` at the falling edge that follows T+1.
- R4: With WIDE_MODE=0 the array holds 2^(ADDR_W+1) words. Address A always maps first word to word index 2A and second word to word index 2A+1.
- R5: With WIDE_MODE=1 the array holds 2^ADDR_W words. Address A maps first word to index (A with bit 0 cleared) + (A[0]) and second word to index (A with bit 0 cleared) + (1 - A[0]).
- R6: With `dll_on`=1, a read at rising edge T drives its first word in the low phase after edge T+1 and its second word in the high phase after edge T+2.
- R7: With `dll_on`=0, a read at rising edge T drives its first word in the high phase after edge T+1 and its second word in the low phase that follows.
- R8: `rvalid` is 1 exactly during the two phases of each read burst. Whenever `rvalid` is 0, `rdata` is all zeros.
- R9: A read that follows a write to the same address in the next cycle returns the newly written words. A write that follows a read in the next cycle does not alter that read's words.
- R10: `echo_p` equals the launch clock level and `echo_n` is its complement at all times.
- R11: Idle cycles leave the array unchanged, whatever `rw_sel`, `addr` and `wdata` carry.
- R12: With USE_OCLK=0 the `oclk` input is ignored and read words and echo strobes follow `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; commands on rising edge, second write word on falling edge |
| oclk | input | 1 | Output launch clock, used when USE_OCLK=1 |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low command strobe |
| rw_sel | input | 1 | 1 selects read, 0 selects write |
| addr | input | ADDR_W | Burst address |
| dll_on | input | 1 | Latency mode: 1 gives 1.5-cycle reads, 0 gives 1-cycle reads |
| wdata | input | WORD_W | Write data, one word per clock phase |
| rdata | output | WORD_W | Read data, one word per clock phase, zero when idle |
| rvalid | output | 1 | High while a read word is being driven |
| echo_p | output | 1 | Echo strobe in phase with the launch clock |
| echo_n | output | 1 | Complementary echo strobe |

## Verification
The checker watches four things on every clock. A quiet bus carries zeros. Two cycles after each read command the low phase is marked valid, and it is never marked valid without one. The echo strobes are always complementary. Every internal write can be traced to a write command two edges earlier. Some behaviours only the bench's scenarios can show: the exact phase of each word in both latency modes, and the word order in both width modes. The bench also covers read-after-write and write-after-read to the same address, idle cycles that carry garbage, and the fact that a tied-off output clock is ignored. It shows these by comparing every half-cycle against a shadow memory.

// File: rtl/ddr_b2_pkg.sv
`timescale 1ns/1ps
package ddr_b2_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;
        logic dll;
    } ctl_t;

    function automatic op_e decode_op(input logic ld_n, input logic rw_sel);
        if (ld_n)
            return OP_IDLE;
        return rw_sel ? OP_READ : OP_WRITE;
    endfunction

    // word index of one beat of a burst
    function automatic int unsigned word_slot(input int unsigned a,
                                              input logic beat,
                                              input bit wide);
        if (wide)
            return (a & ~32'd1) | ((a & 32'd1) ^ {31'd0, beat});
        return (a << 1) | {31'd0, beat};
    endfunction

endpackage

// File: rtl/ddr_b2_cmd_in.sv
`timescale 1ns/1ps
module ddr_b2_cmd_in
    import ddr_b2_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              rw_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dll_on,
    output ctl_t              ctl_q,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{op: OP_IDLE, dll: 1'b0};
            addr_q <= '0;
        end else begin
            ctl_q.op  <= decode_op(ld_n, rw_sel);
            ctl_q.dll <= dll_on;
            addr_q    <= addr;
        end
    end

endmodule

// File: rtl/ddr_b2_wr_cap.sv
`timescale 1ns/1ps
module ddr_b2_wr_cap
    import ddr_b2_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [WORD_W-1:0] wdata,
    output logic              pend,
    output logic [ADDR_W-1:0] waddr,
    output logic [WORD_W-1:0] wd0,
    output logic [WORD_W-1:0] wd1
);

    // first word on the rising edge after the command cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            waddr <= '0;
            wd0   <= '0;
        end else begin
            pend  <= (op_q == OP_WRITE);
            waddr <= addr_q;
            wd0   <= wdata;
        end
    end

    // second word is taken by the array on the falling edge itself
    assign wd1 = wdata;

endmodule

// File: rtl/ddr_b2_store.sv
`timescale 1ns/1ps
module ddr_b2_store #(
    parameter int WORD_W = 18,
    parameter int IDX_W  = 5,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx0,
    input  logic [IDX_W-1:0]  widx1,
    input  logic [WORD_W-1:0] wd0,
    input  logic [WORD_W-1:0] wd1,
    input  logic [IDX_W-1:0]  ridx0,
    input  logic [IDX_W-1:0]  ridx1,
    output logic [WORD_W-1:0] rd0,
    output logic [WORD_W-1:0] rd1
);

    logic [WORD_W-1:0] cells [DEPTH];

    // commit on the falling edge so a read fetched at the next rising edge sees it
    always_ff @(negedge clk) begin
        if (we) begin
            cells[widx0] <= wd0;
            cells[widx1] <= wd1;
        end
    end

    assign rd0 = cells[ridx0];
    assign rd1 = cells[ridx1];

endmodule

// File: rtl/ddr_b2_rd_launch.sv
`timescale 1ns/1ps
module ddr_b2_rd_launch #(
    parameter int WORD_W   = 18,
    parameter bit USE_OCLK = 1'b1
) (
    input  logic              clk,
    input  logic              oclk,
    input  logic              rst,
    input  logic              fetch,
    input  logic              dll,
    input  logic [WORD_W-1:0] rd0,
    input  logic [WORD_W-1:0] rd1,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid,
    output logic              echo_p,
    output logic              echo_n
);

    logic              lclk;
    logic [WORD_W-1:0] hold0, hold1;
    logic              hold_v;
    logic [WORD_W-1:0] q_hi, q_lo;
    logic              v_hi, v_lo;

    generate
        if (USE_OCLK) begin : g_oclk
            assign lclk = oclk;
        end else begin : g_kclk
            assign lclk = clk;
        end
    endgenerate

    // fetch stage: both beats leave the array on one rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            hold0  <= '0;
            hold1  <= '0;
            hold_v <= 1'b0;
        end else begin
            hold0  <= rd0;
            hold1  <= rd1;
            hold_v <= fetch;
        end
    end

    // high-phase launch
    always_ff @(posedge lclk) begin
        if (rst) begin
            q_hi <= '0;
            v_hi <= 1'b0;
        end else if (dll) begin
            q_hi <= hold1;
            v_hi <= hold_v;
        end else begin
            q_hi <= rd0;
            v_hi <= fetch;
        end
    end

    // low-phase launch
    always_ff @(negedge lclk) begin
        if (rst) begin
            q_lo <= '0;
            v_lo <= 1'b0;
        end else begin
            q_lo <= dll ? hold0 : hold1;
            v_lo <= hold_v;
        end
    end

    always_comb begin
        rvalid = lclk ? v_hi : v_lo;
        rdata  = '0;
        if (rvalid)
            rdata = lclk ? q_hi : q_lo;
    end

    assign echo_p = lclk;
    assign echo_n = ~lclk;

endmodule

// File: rtl/ddr_burst2_sram.sv
`timescale 1ns/1ps
module ddr_burst2_sram
    import ddr_b2_pkg::*;
#(
    parameter int WORD_W    = 18,
    parameter int ADDR_W    = 4,
    parameter bit WIDE_MODE = 1'b1,
    parameter bit USE_OCLK  = 1'b1
) (
    input  logic              clk,
    input  logic              oclk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              rw_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dll_on,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid,
    output logic              echo_p,
    output logic              echo_n
);

    localparam int IDX_W = WIDE_MODE ? ADDR_W : ADDR_W + 1;

    ctl_t              ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_pend;
    logic [ADDR_W-1:0] waddr;
    logic [WORD_W-1:0] wd0, wd1, rd0, rd1;
    logic [IDX_W-1:0]  widx0, widx1, ridx0, ridx1;

    ddr_b2_cmd_in #(.ADDR_W(ADDR_W)) u_cmd (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rw_sel(rw_sel), .addr(addr),
        .dll_on(dll_on), .ctl_q(ctl_q), .addr_q(addr_q)
    );

    ddr_b2_wr_cap #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wr (
        .clk(clk), .rst(rst), .op_q(ctl_q.op), .addr_q(addr_q), .wdata(wdata),
        .pend(wr_pend), .waddr(waddr), .wd0(wd0), .wd1(wd1)
    );

    assign widx0 = IDX_W'(word_slot(32'(waddr),  1'b0, WIDE_MODE));
    assign widx1 = IDX_W'(word_slot(32'(waddr),  1'b1, WIDE_MODE));
    assign ridx0 = IDX_W'(word_slot(32'(addr_q), 1'b0, WIDE_MODE));
    assign ridx1 = IDX_W'(word_slot(32'(addr_q), 1'b1, WIDE_MODE));

    ddr_b2_store #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .we(wr_pend), .widx0(widx0), .widx1(widx1),
        .wd0(wd0), .wd1(wd1), .ridx0(ridx0), .ridx1(ridx1),
        .rd0(rd0), .rd1(rd1)
    );

    ddr_b2_rd_launch #(.WORD_W(WORD_W), .USE_OCLK(USE_OCLK)) u_rd (
        .clk(clk), .oclk(oclk), .rst(rst), .fetch(ctl_q.op == OP_READ),
        .dll(ctl_q.dll), .rd0(rd0), .rd1(rd1), .rdata(rdata),
        .rvalid(rvalid), .echo_p(echo_p), .echo_n(echo_n)
    );

endmodule

// File: rtl/ddr_b2_sram_chk.sv
`timescale 1ns/1ps
module ddr_b2_sram_chk #(
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_n,
    input logic              rw_sel,
    input logic [WORD_W-1:0] rdata,
    input logic              rvalid,
    input logic              echo_p,
    input logic              echo_n,
    input logic              wr_pend
);

    assert_quiet_hi_R8: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> rdata == '0);

    assert_quiet_lo_R8: assert property (@(negedge clk) disable iff (rst)
        !rvalid |-> rdata == '0);

    // low phase after edge T+1 carries a beat of any read taken at T (R6, R7)
    assert_read_lands_R6: assert property (@(posedge clk) disable iff (rst)
        (!ld_n && rw_sel) |=> ##1 rvalid);

    assert_no_phantom_R8: assert property (@(posedge clk) disable iff (rst)
        !(!ld_n && rw_sel) |=> ##1 !rvalid);

    assert_echo_pair_R10: assert property (@(posedge clk) disable iff (rst)
        echo_p != echo_n);

    assert_write_source_R3: assert property (@(posedge clk) disable iff (rst)
        wr_pend |-> $past(!ld_n && !rw_sel, 2));

endmodule

bind ddr_burst2_sram ddr_b2_sram_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .ld_n(ld_n), .rw_sel(rw_sel), .rdata(rdata),
    .rvalid(rvalid), .echo_p(echo_p), .echo_n(echo_n), .wr_pend(wr_pend)
);

// File: tb/ddr_burst2_sram_test.sv
`timescale 1ns/1ps
module ddr_burst2_sram_test;

    localparam int WW = 18;
    localparam int AW = 4;
    localparam int NS = 2048;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_n = 1'b1;
    logic          rw_sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          dll_on = 1'b1;
    logic [WW-1:0] wdata = '0;
    logic          oclk_dead = 1'b0;

    logic [WW-1:0] rd_w, rd_n;
    logic          rv_w, rv_n, ep_w, en_w, ep_n, en_n;

    always #2 clk = ~clk;   // 250 MHz

    ddr_burst2_sram #(.WORD_W(WW), .ADDR_W(AW), .WIDE_MODE(1'b1), .USE_OCLK(1'b1)) uut (
        .clk(clk), .oclk(clk), .rst(rst), .ld_n(ld_n), .rw_sel(rw_sel), .addr(addr),
        .dll_on(dll_on), .wdata(wdata), .rdata(rd_w), .rvalid(rv_w),
        .echo_p(ep_w), .echo_n(en_w)
    );

    // narrow order, launched from clk; oclk tied low (R12)
    ddr_burst2_sram #(.WORD_W(WW), .ADDR_W(AW), .WIDE_MODE(1'b0), .USE_OCLK(1'b0)) uut_n (
        .clk(clk), .oclk(oclk_dead), .rst(rst), .ld_n(ld_n), .rw_sel(rw_sel), .addr(addr),
        .dll_on(dll_on), .wdata(wdata), .rdata(rd_n), .rvalid(rv_n),
        .echo_p(ep_n), .echo_n(en_n)
    );

    int            n_chk = 0;
    int            n_bad = 0;
    int            k = 0;
    bit            done = 0;
    string         scen = "R1";

    logic [WW-1:0] sh_w [32];
    logic [WW-1:0] sh_n [32];
    bit            exp_v [NS];
    logic [WW-1:0] exp_w [NS];
    logic [WW-1:0] exp_n [NS];

    bit            pw = 0;
    logic [WW-1:0] pw0 = '0, pw1 = '0;

    function automatic int idx_wide(int a, int b);
        return (a & 14) | ((a & 1) ^ b);    // R5
    endfunction

    function automatic int idx_narrow(int a, int b);
        return a * 2 + b;                   // R4
    endfunction

    task automatic cmp(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] slot %0d: actual %h expected %h", tag, scen, k, act, exp);
        end
    endtask

    task automatic check_slot(int h, bit hi);
        cmp("R8 valid wide",   WW'(rv_w), WW'(exp_v[h]));
        cmp("R8 valid narrow", WW'(rv_n), WW'(exp_v[h]));
        cmp("R5 data wide",    rd_w, exp_v[h] ? exp_w[h] : '0);
        cmp("R4 data narrow",  rd_n, exp_v[h] ? exp_n[h] : '0);
        cmp("R10 echo",        WW'({ep_w, en_w}), WW'({hi, !hi}));
        cmp("R12 echo on clk", WW'({ep_n, en_n}), WW'({hi, !hi}));
    endtask

    // one clock: entered and left in the low phase
    task automatic tick(bit ld, bit rw, int a);
        logic [WW-1:0] c0, c1;
        bit            cv;
        int            s0, s1;
        cv = pw; c0 = pw0; c1 = pw1;
        pw = 0;
        ld_n = ld; rw_sel = rw; addr = AW'(a);
        wdata = cv ? c0 : 18'h2A5A5;
        if (!ld && rw) begin               // R2 read
            s0 = dll_on ? 2*k + 3 : 2*k + 2;   // R6 / R7
            s1 = s0 + 1;
            exp_v[s0] = 1; exp_v[s1] = 1;
            exp_w[s0] = sh_w[idx_wide(a, 0)];  exp_w[s1] = sh_w[idx_wide(a, 1)];
            exp_n[s0] = sh_n[idx_narrow(a, 0)]; exp_n[s1] = sh_n[idx_narrow(a, 1)];
        end else if (!ld && !rw) begin     // R2 write, data next cycle (R3)
            pw  = 1;
            pw0 = WW'(k * 37 + a * 5 + 1);
            pw1 = WW'(k * 91 + a * 3 + 7) ^ 18'h15555;
            sh_w[idx_wide(a, 0)] = pw0;   sh_w[idx_wide(a, 1)] = pw1;
            sh_n[idx_narrow(a, 0)] = pw0; sh_n[idx_narrow(a, 1)] = pw1;
        end
        @(posedge clk); #1;
        check_slot(2*k, 1'b1);
        wdata = cv ? c1 : 18'h3C3C3;
        @(negedge clk); #1;
        check_slot(2*k + 1, 1'b0);
        k++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0, i);
    endtask

    initial begin
        #1;
        scen = "R1";
        idle(3);
        rst = 1'b0;
        idle(2);

        scen = "R3";
        for (int a = 0; a < 16; a++) tick(1'b0, 1'b0, a);
        idle(2);

        scen = "R6";
        for (int a = 15; a >= 0; a--) tick(1'b0, 1'b1, a);
        idle(3);

        dll_on = 1'b0;
        idle(2);
        scen = "R7";
        for (int a = 0; a < 16; a++) tick(1'b0, 1'b1, a);
        idle(3);

        scen = "R9";
        for (int a = 3; a < 9; a++) begin
            tick(1'b0, 1'b0, a);
            tick(1'b0, 1'b1, a);
            tick(1'b0, 1'b0, a);
        end
        tick(1'b0, 1'b1, 8);
        idle(3);
        dll_on = 1'b1;
        idle(2);
        for (int a = 9; a < 14; a++) begin
            tick(1'b0, 1'b0, a);
            tick(1'b0, 1'b1, a);
            tick(1'b0, 1'b0, a);
        end
        tick(1'b0, 1'b1, 13);
        idle(3);

        scen = "R11";
        for (int i = 0; i < 8; i++) tick(1'b1, i[0], (i * 7) & 15);
        for (int a = 0; a < 16; a++) tick(1'b0, 1'b1, a);
        idle(3);

        scen = "R2";
        for (int i = 0; i < 40; i++) begin
            if (i % 3 == 2) tick(1'b1, 1'b1, i & 15);
            else            tick(1'b0, i[0], (i * 5) & 15);
        end
        idle(4);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule